// File: doc/BRIEF.md
# Privileged Interrupt Request Register Unit

This block is a bank of software-written control registers sitting beside a processor core. Software stores a pending word of software interrupts, a processor interrupt level, a hypervisor pending value, four pairs of message and error queue pointers, a trap vector base, a hypervisor state word and the current trap level. From those stored values the unit derives a set of registered interrupt request lines that the core's trap logic consumes.

Software interrupts are filtered by the interrupt level. The two special lines, index 0 and the top index, are held off whenever the level is 14 or more. A queue raises its request whenever its head and tail pointers differ. The trap-level-zero line combines a flag in the state word with the trap level and the hyper-privileged bit. A version word can be read but not written; a write to it is dropped and flagged for one cycle. Registers are written through a single address/data/enable port and read through a combinational read port.

Top module: `priv_irq_regs`

## Requirements
- R1: After reset every stored register reads zero, except the state word, whose identifier bit (bit 11) reads 1; every request output and the error flag are low.
- R2: Software request lines 0 and 16 follow pending bits 0 and 16 while the interrupt level is below 14, and are low when the level is 14 or 15.
- R3: For index i from 1 to 15, software request i is high only when pending bit i is set and i is strictly greater than the interrupt level.
- R4: The hypervisor request is high exactly when the hypervisor pending register is nonzero.
- R5: Queue request q (0 CPU messages, 1 device messages, 2 resumable errors) is high exactly when that queue's head and tail differ; queue q's head is at address 8+2q and its tail at 9+2q.
- R6: The fourth queue pair (non-resumable errors, addresses 14 and 15) is stored and readable but changes no request output.
- R7: The trap vector base register (address 3) always stores and returns zero in bits 14 to 0.
- R8: A write to the state word (address 4) sets its identifier bit 11 to 1 whatever the written data.
- R9: The trap-level-zero request is high exactly when state bit 0 is set, state bit 2 is clear and the trap level (address 5) is zero.
- R10: A write accepted at clock edge k is visible on the read port after edge k and on the request outputs after edge k+1; writes to the interrupt level (address 1) and trap level re-evaluate the requests the same way.
- R11: A write to the version word (address 6) changes no stored value and raises the error flag for exactly the cycle after edge k.
- R12: The read port returns the stored value of the addressed register combinationally, zero-extended; other addresses (softpend 0, hypervisor pending 2) follow the map above, and the version word reads its fixed parameter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Write register address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 5 | Read register address |
| rd_data | output | DATA_W | Read data of the addressed register |
| soft_req | output | 2**LVL_W+1 | Masked software interrupt requests |
| hv_req | output | 1 | Hypervisor interrupt request |
| queue_req | output | 3 | Queue-not-empty requests, one per signalling queue |
| tlz_req | output | 1 | Trap-level-zero request |
| wr_err | output | 1 | One-cycle flag for a write to the read-only version word |

## Verification
On every cycle the checker ties each request output to the register values of the previous cycle: the special software lines against the level limit, the line at the current level never high, the hypervisor, queue and trap-level-zero lines against their sources, and the error flag against a version write one cycle earlier; it also watches the masked base bits and the identifier bit. Only the bench's scenarios show that particular level settings produce the full expected masks, that the fourth queue pair changes nothing while remaining readable, that the read port returns the right contents for every address, and that the request lines lag the write by exactly one extra edge.

// File: rtl/priv_irq_pkg.sv
package priv_irq_pkg;

   localparam int ADDR_W = 5;

   // register map
   typedef enum logic [ADDR_W-1:0] {
      A_SOFTPEND = 5'd0,
      A_LEVEL    = 5'd1,
      A_HVPEND   = 5'd2,
      A_TBA      = 5'd3,
      A_HSTATE   = 5'd4,
      A_TRAPLVL  = 5'd5,
      A_VERSION  = 5'd6,
      A_Q0_HEAD  = 5'd8,
      A_Q0_TAIL  = 5'd9,
      A_Q1_HEAD  = 5'd10,
      A_Q1_TAIL  = 5'd11,
      A_Q2_HEAD  = 5'd12,
      A_Q2_TAIL  = 5'd13,
      A_Q3_HEAD  = 5'd14,
      A_Q3_TAIL  = 5'd15
   } reg_addr_e;

   // queue window: addr[4:3] == QWIN, addr[2:1] = queue, addr[0] = tail select
   localparam logic [1:0] QWIN = 2'b01;

   localparam int NUM_Q     = 4;
   localparam int NUM_REQ_Q = 3;

   // state word fields
   localparam int HS_TLZ_BIT   = 0;
   localparam int HS_HPRIV_BIT = 2;
   localparam int HS_ID_BIT    = 11;

endpackage

// File: rtl/priv_irq_softmask.sv
module priv_irq_softmask #(
   parameter int LVL_W    = 4,
   parameter int HI_LIMIT = 14,
   localparam int SOFT_W  = (2**LVL_W) + 1
) (
   input  logic [SOFT_W-1:0] pend,
   input  logic [LVL_W-1:0]  level,
   output logic [SOFT_W-1:0] req
);

   logic below_limit;
   assign below_limit = ({1'b0, level} < (LVL_W+1)'(HI_LIMIT));

   for (genvar i = 0; i < SOFT_W; i++) begin : g_bit
      if (i == 0 || i == SOFT_W-1) begin : g_special
         assign req[i] = pend[i] & below_limit;
      end else begin : g_ranked
         assign req[i] = pend[i] & ((LVL_W+1)'(i) > {1'b0, level});
      end
   end

endmodule

// File: rtl/priv_irq_qpair.sv
module priv_irq_qpair #(
   parameter int PTR_W   = 16,
   parameter bit HAS_REQ = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_head,
   input  logic             wr_tail,
   input  logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] head,
   output logic [PTR_W-1:0] tail,
   output logic             req
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head <= '0;
         tail <= '0;
      end else begin
         if (wr_head) head <= wr_ptr;
         if (wr_tail) tail <= wr_ptr;
      end
   end

   if (HAS_REQ) begin : g_req
      assign req = (head != tail);
   end else begin : g_noreq
      assign req = 1'b0;
   end

endmodule

// File: rtl/priv_irq_regs.sv
module priv_irq_regs
   import priv_irq_pkg::*;
#(
   parameter int          DATA_W        = 64,
   parameter int          LVL_W         = 4,
   parameter int          HI_LIMIT      = 14,
   parameter int          HVP_W         = 8,
   parameter int          TL_W          = 3,
   parameter int          QPTR_W        = 16,
   parameter int          HS_W          = 12,
   parameter int          TBA_ZERO_BITS = 15,
   parameter logic [63:0] VERSION_VAL   = 64'h0033_0021_0500_0607
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic [ADDR_W-1:0]     rd_addr,
   output logic [DATA_W-1:0]     rd_data,
   output logic [(2**LVL_W):0]   soft_req,
   output logic                  hv_req,
   output logic [NUM_REQ_Q-1:0]  queue_req,
   output logic                  tlz_req,
   output logic                  wr_err
);

   localparam int SOFT_W = (2**LVL_W) + 1;
   localparam logic [HS_W-1:0] HS_RESET = HS_W'(1) << HS_ID_BIT;
   localparam logic [DATA_W-TBA_ZERO_BITS-1:0] TBA_HI_ZERO = '0;

   // elaboration checks
   if (DATA_W < SOFT_W) begin : g_chk_soft
      $error("DATA_W too narrow for software pending word");
   end
   if (TBA_ZERO_BITS >= DATA_W) begin : g_chk_tba
      $error("TBA_ZERO_BITS must be below DATA_W");
   end
   if (HS_W <= HS_ID_BIT) begin : g_chk_hs
      $error("HS_W must hold the identifier bit");
   end
   if (QPTR_W > DATA_W || HVP_W > DATA_W || TL_W > DATA_W) begin : g_chk_w
      $error("register field wider than data port");
   end
   if (HI_LIMIT > 2**LVL_W) begin : g_chk_lim
      $error("HI_LIMIT out of level range");
   end

   // stored registers
   logic [SOFT_W-1:0]   soft_q;
   logic [LVL_W-1:0]    level_q;
   logic [HVP_W-1:0]    hvpend_q;
   logic [DATA_W-1:0]   tba_q;
   logic [HS_W-1:0]     hstate_q;
   logic [TL_W-1:0]     trap_lvl_q;

   logic [NUM_Q-1:0][QPTR_W-1:0] q_head;
   logic [NUM_Q-1:0][QPTR_W-1:0] q_tail;
   logic [NUM_Q-1:0]             q_wr_head;
   logic [NUM_Q-1:0]             q_wr_tail;
   logic [NUM_Q-1:0]             q_req_raw;

   logic                wr_in_qwin;
   logic                rd_in_qwin;
   logic [SOFT_W-1:0]   soft_next;
   logic                tlz_next;
   logic                ver_write;

   assign wr_in_qwin = (wr_addr[ADDR_W-1:3] == QWIN);
   assign rd_in_qwin = (rd_addr[ADDR_W-1:3] == QWIN);
   assign ver_write  = wr_en && (wr_addr == A_VERSION);

   // scalar register writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         soft_q     <= '0;
         level_q    <= '0;
         hvpend_q   <= '0;
         tba_q      <= '0;
         hstate_q   <= HS_RESET;
         trap_lvl_q <= '0;
      end else if (wr_en) begin
         case (reg_addr_e'(wr_addr))
            A_SOFTPEND: soft_q     <= wr_data[SOFT_W-1:0];
            A_LEVEL:    level_q    <= wr_data[LVL_W-1:0];
            A_HVPEND:   hvpend_q   <= wr_data[HVP_W-1:0];
            A_TBA:      tba_q      <= {wr_data[DATA_W-1:TBA_ZERO_BITS],
                                       {TBA_ZERO_BITS{1'b0}}};
            A_HSTATE:   hstate_q   <= wr_data[HS_W-1:0] | HS_RESET;
            A_TRAPLVL:  trap_lvl_q <= wr_data[TL_W-1:0];
            default: ;
         endcase
      end
   end

   // queue pointer pairs
   for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
      assign q_wr_head[q] = wr_en && wr_in_qwin && (wr_addr[2:1] == 2'(q)) && !wr_addr[0];
      assign q_wr_tail[q] = wr_en && wr_in_qwin && (wr_addr[2:1] == 2'(q)) &&  wr_addr[0];

      priv_irq_qpair #(
         .PTR_W   (QPTR_W),
         .HAS_REQ (q < NUM_REQ_Q)
      ) u_qpair (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_head (q_wr_head[q]),
         .wr_tail (q_wr_tail[q]),
         .wr_ptr  (wr_data[QPTR_W-1:0]),
         .head    (q_head[q]),
         .tail    (q_tail[q]),
         .req     (q_req_raw[q])
      );
   end

   logic [NUM_Q-NUM_REQ_Q-1:0] unused_q_req;
   assign unused_q_req = q_req_raw[NUM_Q-1:NUM_REQ_Q];

   // software interrupt masking
   priv_irq_softmask #(
      .LVL_W    (LVL_W),
      .HI_LIMIT (HI_LIMIT)
   ) u_softmask (
      .pend  (soft_q),
      .level (level_q),
      .req   (soft_next)
   );

   assign tlz_next = hstate_q[HS_TLZ_BIT] && !hstate_q[HS_HPRIV_BIT] &&
                     (trap_lvl_q == '0);

   // registered request outputs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         soft_req  <= '0;
         hv_req    <= 1'b0;
         queue_req <= '0;
         tlz_req   <= 1'b0;
         wr_err    <= 1'b0;
      end else begin
         soft_req  <= soft_next;
         hv_req    <= |hvpend_q;
         queue_req <= q_req_raw[NUM_REQ_Q-1:0];
         tlz_req   <= tlz_next;
         wr_err    <= ver_write;
      end
   end

   // read port
   always_comb begin
      rd_data = '0;
      if (rd_in_qwin) begin
         rd_data[QPTR_W-1:0] = rd_addr[0] ? q_tail[rd_addr[2:1]] : q_head[rd_addr[2:1]];
      end else begin
         case (reg_addr_e'(rd_addr))
            A_SOFTPEND: rd_data[SOFT_W-1:0] = soft_q;
            A_LEVEL:    rd_data[LVL_W-1:0]  = level_q;
            A_HVPEND:   rd_data[HVP_W-1:0]  = hvpend_q;
            A_TBA:      rd_data             = tba_q;
            A_HSTATE:   rd_data[HS_W-1:0]   = hstate_q;
            A_TRAPLVL:  rd_data[TL_W-1:0]   = trap_lvl_q;
            A_VERSION:  rd_data             = DATA_W'(VERSION_VAL);
            default:    rd_data             = '0;
         endcase
      end
   end

   logic unused_tba_hi;
   assign unused_tba_hi = (TBA_HI_ZERO != '0);

endmodule

// File: rtl/priv_irq_regs_chk.sv
module priv_irq_regs_chk
   import priv_irq_pkg::*;
#(
   parameter int DATA_W        = 64,
   parameter int LVL_W         = 4,
   parameter int HI_LIMIT      = 14,
   parameter int HVP_W         = 8,
   parameter int TL_W          = 3,
   parameter int QPTR_W        = 16,
   parameter int HS_W          = 12,
   parameter int TBA_ZERO_BITS = 15
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          wr_en,
   input logic [ADDR_W-1:0]             wr_addr,
   input logic [2**LVL_W:0]             soft_q,
   input logic [LVL_W-1:0]              level_q,
   input logic [HVP_W-1:0]              hvpend_q,
   input logic [DATA_W-1:0]             tba_q,
   input logic [HS_W-1:0]               hstate_q,
   input logic [TL_W-1:0]               trap_lvl_q,
   input logic [NUM_Q-1:0][QPTR_W-1:0]  q_head,
   input logic [NUM_Q-1:0][QPTR_W-1:0]  q_tail,
   input logic [2**LVL_W:0]             soft_req,
   input logic                          hv_req,
   input logic [NUM_REQ_Q-1:0]          queue_req,
   input logic                          tlz_req,
   input logic                          wr_err
);

   localparam int TOP = 2**LVL_W;

   // R2: special lines need the pending bit and a level below the limit
   a_r2_special_hi: assert property (@(posedge clk) disable iff (!rst_n)
      soft_req[TOP] |-> $past(soft_q[TOP] && ({1'b0, level_q} < (LVL_W+1)'(HI_LIMIT))));
   a_r2_special_lo: assert property (@(posedge clk) disable iff (!rst_n)
      soft_req[0] |-> $past(soft_q[0] && ({1'b0, level_q} < (LVL_W+1)'(HI_LIMIT))));

   // R3: the line at the current level is never requested
   a_r3_at_level_masked: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(level_q) != '0) |-> !soft_req[$past(level_q)]);
   a_r3_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_req & ~$past(soft_q)) == '0);

   // R4
   a_r4_hv_follows: assert property (@(posedge clk) disable iff (!rst_n)
      hv_req == $past(hvpend_q != '0));

   // R5
   a_r5_q0: assert property (@(posedge clk) disable iff (!rst_n)
      queue_req[0] == $past(q_head[0] != q_tail[0]));
   a_r5_q1: assert property (@(posedge clk) disable iff (!rst_n)
      queue_req[1] == $past(q_head[1] != q_tail[1]));
   a_r5_q2: assert property (@(posedge clk) disable iff (!rst_n)
      queue_req[2] == $past(q_head[2] != q_tail[2]));

   // R7
   a_r7_tba_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      tba_q[TBA_ZERO_BITS-1:0] == '0);

   // R8
   a_r8_id_set: assert property (@(posedge clk) disable iff (!rst_n)
      hstate_q[HS_ID_BIT]);

   // R9
   a_r9_tlz_source: assert property (@(posedge clk) disable iff (!rst_n)
      tlz_req |-> $past(hstate_q[HS_TLZ_BIT] && !hstate_q[HS_HPRIV_BIT] && trap_lvl_q == '0));

   // R11
   a_r11_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> $past(wr_en && wr_addr == A_VERSION));
   a_r11_err_raised: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_VERSION) |=> wr_err);

endmodule

bind priv_irq_regs priv_irq_regs_chk #(
   .DATA_W        (DATA_W),
   .LVL_W         (LVL_W),
   .HI_LIMIT      (HI_LIMIT),
   .HVP_W         (HVP_W),
   .TL_W          (TL_W),
   .QPTR_W        (QPTR_W),
   .HS_W          (HS_W),
   .TBA_ZERO_BITS (TBA_ZERO_BITS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .soft_q     (soft_q),
   .level_q    (level_q),
   .hvpend_q   (hvpend_q),
   .tba_q      (tba_q),
   .hstate_q   (hstate_q),
   .trap_lvl_q (trap_lvl_q),
   .q_head     (q_head),
   .q_tail     (q_tail),
   .soft_req   (soft_req),
   .hv_req     (hv_req),
   .queue_req  (queue_req),
   .tlz_req    (tlz_req),
   .wr_err     (wr_err)
);

// File: tb/priv_irq_regs_tb_top.sv
module priv_irq_regs_tb_top;

   localparam logic [63:0] VER = 64'h0033_0021_0500_0607;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [63:0] wr_data = '0;
   logic [4:0]  rd_addr = '0;
   logic [63:0] rd_data;
   logic [16:0] soft_req;
   logic        hv_req;
   logic [2:0]  queue_req;
   logic        tlz_req;
   logic        wr_err;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   priv_irq_regs dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .soft_req  (soft_req),
      .hv_req    (hv_req),
      .queue_req (queue_req),
      .tlz_req   (tlz_req),
      .wr_err    (wr_err)
   );

   // ---------------- behavioural reference model ----------------
   logic [16:0] m_soft;
   int          m_lvl;
   logic [7:0]  m_hv;
   logic [15:0] m_head [4];
   logic [15:0] m_tail [4];
   logic [63:0] m_tba;
   logic [11:0] m_hs;
   int          m_tl;
   logic [16:0] e_soft;
   logic        e_hv, e_tlz, e_err;
   logic [2:0]  e_q;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_soft = '0; m_lvl = 0; m_hv = '0; m_tba = '0; m_hs = 12'h800; m_tl = 0;
         for (int i = 0; i < 4; i++) begin m_head[i] = '0; m_tail[i] = '0; end
         e_soft = '0; e_hv = 0; e_tlz = 0; e_err = 0; e_q = '0;
      end else begin
         for (int i = 0; i <= 16; i++) begin
            if (i == 0 || i == 16) e_soft[i] = m_soft[i] && (m_lvl < 14);
            else                   e_soft[i] = m_soft[i] && (i > m_lvl);
         end
         e_hv  = (m_hv != 0);
         for (int i = 0; i < 3; i++) e_q[i] = (m_head[i] != m_tail[i]);
         e_tlz = m_hs[0] && !m_hs[2] && (m_tl == 0);
         e_err = wr_en && (wr_addr == 5'd6);
         if (wr_en) begin
            case (wr_addr)
               5'd0: m_soft = wr_data[16:0];
               5'd1: m_lvl  = int'(wr_data[3:0]);
               5'd2: m_hv   = wr_data[7:0];
               5'd3: m_tba  = wr_data & ~64'h7FFF;
               5'd4: m_hs   = wr_data[11:0] | 12'h800;
               5'd5: m_tl   = int'(wr_data[2:0]);
               default: begin
                  if (wr_addr >= 5'd8 && wr_addr <= 5'd15) begin
                     if (wr_addr[0]) m_tail[wr_addr[2:1]] = wr_data[15:0];
                     else            m_head[wr_addr[2:1]] = wr_data[15:0];
                  end
               end
            endcase
         end
      end
   end

   function automatic logic [63:0] m_read(input logic [4:0] a);
      if (a >= 5'd8 && a <= 5'd15) return {48'h0, (a[0] ? m_tail[a[2:1]] : m_head[a[2:1]])};
      case (a)
         5'd0: return {47'h0, m_soft};
         5'd1: return 64'(m_lvl);
         5'd2: return {56'h0, m_hv};
         5'd3: return m_tba;
         5'd4: return {52'h0, m_hs};
         5'd5: return 64'(m_tl);
         5'd6: return VER;
         default: return 64'h0;
      endcase
   endfunction

   // per-cycle comparison, 2 ns after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (rst_n) begin
            n_tests += 6;
            if (soft_req !== e_soft) begin n_fail++; $display("FAIL R3 model soft_req act=%h exp=%h", soft_req, e_soft); end
            if (hv_req !== e_hv)     begin n_fail++; $display("FAIL R4 model hv_req act=%b exp=%b", hv_req, e_hv); end
            if (queue_req !== e_q)   begin n_fail++; $display("FAIL R5 model queue_req act=%b exp=%b", queue_req, e_q); end
            if (tlz_req !== e_tlz)   begin n_fail++; $display("FAIL R9 model tlz_req act=%b exp=%b", tlz_req, e_tlz); end
            if (wr_err !== e_err)    begin n_fail++; $display("FAIL R11 model wr_err act=%b exp=%b", wr_err, e_err); end
            if (rd_data !== m_read(rd_addr)) begin
               n_fail++; $display("FAIL R12 model rd_data act=%h exp=%h", rd_data, m_read(rd_addr));
            end
         end
      end
   end

   // ---------------- directed scenarios ----------------
   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [63:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [63:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   logic [63:0] v;

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 soft_req at reset", 64'(soft_req), 64'h0);
      chk("R1 other requests at reset", {60'h0, hv_req, tlz_req, wr_err, |queue_req}, 64'h0);
      rst_n = 1'b1;
      settle();
      rd(5'd4, v); chk("R1 state word id bit", v, 64'h800);
      rd(5'd3, v); chk("R1 base reads zero", v, 64'h0);

      // R10 latency, R2/R3 masks
      wr(5'd0, 64'h1FFFF);
      rd(5'd0, v); chk("R10 pending visible after write edge", v, 64'h1FFFF);
      chk("R10 request not yet updated", 64'(soft_req), 64'h0);
      settle();
      chk("R10 R3 request after next edge level 0", 64'(soft_req), 64'h1FFFF);
      wr(5'd1, 64'd5); settle();
      chk("R3 level 5 mask", 64'(soft_req), 64'h1FFC1);
      wr(5'd1, 64'd13); settle();
      chk("R2 level 13 mask", 64'(soft_req), 64'h1C001);
      wr(5'd1, 64'd14); settle();
      chk("R2 level 14 mask", 64'(soft_req), 64'h08000);
      wr(5'd1, 64'd15); settle();
      chk("R3 level 15 mask", 64'(soft_req), 64'h0);
      wr(5'd1, 64'd3); wr(5'd0, 64'h00012); settle();
      chk("R3 sparse pending level 3", 64'(soft_req), 64'h10);

      // R4
      wr(5'd2, 64'h80); settle();
      chk("R4 hv pending nonzero", 64'(hv_req), 64'h1);
      wr(5'd2, 64'h0); settle();
      chk("R4 hv pending zero", 64'(hv_req), 64'h0);

      // R5 / R6
      wr(5'd8, 64'd3); settle();
      chk("R5 cpu queue head differs", 64'(queue_req), 64'h1);
      wr(5'd9, 64'd3); settle();
      chk("R5 cpu queue equal", 64'(queue_req), 64'h0);
      wr(5'd11, 64'd7); settle();
      chk("R5 device queue tail differs", 64'(queue_req), 64'h2);
      wr(5'd12, 64'd1); settle();
      chk("R5 resumable queue", 64'(queue_req), 64'h6);
      wr(5'd14, 64'd5); settle();
      chk("R6 non-resumable queue no request", 64'(queue_req), 64'h6);
      rd(5'd14, v); chk("R6 non-resumable head stored", v, 64'h5);

      // R7
      wr(5'd3, 64'hFFFF_FFFF_FFFF_FFFF);
      rd(5'd3, v); chk("R7 base low bits cleared", v, 64'hFFFF_FFFF_FFFF_8000);

      // R8 / R9
      wr(5'd4, 64'h0);
      rd(5'd4, v); chk("R8 id bit forced", v, 64'h800);
      wr(5'd4, 64'h1); settle();
      chk("R9 tlz with trap level 0", 64'(tlz_req), 64'h1);
      wr(5'd5, 64'd1); settle();
      chk("R9 tlz blocked by trap level", 64'(tlz_req), 64'h0);
      wr(5'd5, 64'd0); wr(5'd4, 64'h5); settle();
      chk("R9 tlz blocked by hyper-privileged bit", 64'(tlz_req), 64'h0);
      rd(5'd4, v); chk("R8 id bit with written data", v, 64'h805);

      // R11
      wr(5'd6, 64'h0);
      chk("R11 error flag raised", 64'(wr_err), 64'h1);
      rd(5'd6, v); chk("R11 R12 version unchanged", v, VER);
      settle();
      chk("R11 error flag one cycle", 64'(wr_err), 64'h0);

      // R12 readback
      rd(5'd11, v); chk("R12 device tail read", v, 64'h7);
      rd(5'd1, v);  chk("R12 level read", v, 64'h3);

      repeat (4) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      n_tests++;
      n_fail++;
      $display("FAIL R10 watchdog expired act=running exp=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule